// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block sits on the host side of a three-wire serial sampling converter. From the system clock it makes the serial clock and the convert strobe. It shifts in each conversion result, most significant bit first, and presents it as a parallel word with a one-cycle valid strobe. Every conversion frame lasts 18 serial clocks: 16 carry data and 2 give the converter time to acquire. The word read out in a frame is the value sampled at the convert strobe of the frame before. For that reason the controller marks the first words after start-up or after a wake-up as invalid and drops them.

The controller also puts the converter into its two low-power states and brings it back out. It does this with convert-pulse patterns sent while the serial clock is held still. A request to change mode is honoured only at a frame boundary, so a frame that has started always finishes. A busy flag shows that a frame, a power-down pattern or the wake-up clock is in progress.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, conv_o, sclk_o, valid_o and busy_o are low and data_o is zero.
- R2: One serial clock period is DIV system cycles: sclk_o is low for the first DIV/2 cycles and high for the rest. In a frame, conv_o goes high for exactly one serial period, the first slot of the frame, and rises while sclk_o is low.
- R3: While running continuously, convert pulses start every 18·DIV system cycles, and there are 18 rising edges of sclk_o per frame.
- R4: sdata_i is sampled at each rising edge of sclk_o. The rising edges are numbered from 0, starting with the edge in the convert slot. The bit at edge MSB_POS is the most significant bit. The next RES edges give the word MSB first, in natural binary, for RES of 14 or 12. Bits at all other edges are ignored.
- R5: valid_o is a one-cycle pulse. It is asserted at the same system edge at which sclk_o rises for the last data bit. data_o changes only together with valid_o.
- R6: After reset, or after a stop, the first frame of a new run raises no valid. After a wake from nap, NAP_DISCARD frames raise no valid. After a wake from sleep, SLEEP_DISCARD frames raise no valid.
- R7: Changes on mode_i and run_i take effect only at the end of a frame. The frame in progress completes and still delivers its word.
- R8: mode_i = 01 (nap) sends two convert pulses. Each pulse is one serial period high followed by one period low. sclk_o stays low throughout, and then both pins stay low.
- R9: mode_i = 10 or 11 (sleep) sends SLEEP_PULSES convert pulses of the same shape, with sclk_o held low, and then both pins stay low.
- R10: When the converter is napping or sleeping and mode_i = 00 with run_i high, one serial clock period with conv_o low comes first. The first frame follows it.
- R11: busy_o is high during a frame, a power-down pattern or the wake-up clock. It is low when idle, napping or sleeping. Whenever busy_o is low, conv_o and sclk_o are low.
- R12: When run_i falls, the current frame completes. The controller then goes idle and sends no more pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High: convert continuously |
| mode_i | input | 2 | 00 run, 01 nap, 1x sleep |
| sdata_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Serial clock |
| data_o | output | RES | Last accepted conversion word |
| valid_o | output | 1 | One-cycle strobe for a new data_o |
| busy_o | output | 1 | Frame, power-down pattern or wake clock in progress |

## Verification
The serial pins change only at slot boundaries, which come every DIV system cycles. A data word appears when sclk_o rises for its last bit, so valid_o rises at the same edge as the 16th serial clock of the frame. A mode or run request applies after the 18th slot. The bench drives its inputs and samples the outputs on falling clock edges. It waits on counted convert and serial-clock edges rather than on fixed delays. Its converter model checks, at each valid, that exactly MSB_POS+RES-1 serial clocks have fallen since the convert pulse.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  // protocol constants: slots per conversion frame, pulses in the nap pattern
  localparam int FRAME_SLOTS = 18;
  localparam int NAP_PULSES  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_NAPSEQ,
    ST_NAPPED,
    ST_SLPSEQ,
    ST_SLEEPING,
    ST_WAKE
  } seq_state_e;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_STOP,
    LD_NAP,
    LD_SLEEP
  } disc_load_e;

endpackage

// File: rtl/adc_cap_rstsync.sv
module adc_cap_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adc_cap_clkgen.sv
module adc_cap_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_end,
  output logic sck_hi_nxt,
  output logic sck_rise_nxt
);

  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(DIV / 2);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d         = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    slot_end     = (ph_q == PH_LAST);
    sck_hi_nxt   = (ph_d >= PH_HALF);
    sck_rise_nxt = (ph_d == PH_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq
  import adc_cap_pkg::*;
#(
  parameter int SLEEP_PULSES = 4,
  parameter int SW           = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          sck_hi_nxt,
  input  logic          run_i,
  input  logic [1:0]    mode_i,
  output logic          conv_o,
  output logic          sclk_o,
  output logic          busy_o,
  output logic          in_frame_o,
  output logic [SW-1:0] slot_o,
  output disc_load_e    disc_ld_o
);

  localparam logic [SW-1:0] FR_LAST  = SW'(FRAME_SLOTS - 1);
  localparam logic [SW-1:0] NAP_LAST = SW'(2 * NAP_PULSES - 1);
  localparam logic [SW-1:0] SLP_LAST = SW'(2 * SLEEP_PULSES - 1);

  seq_state_e    st_q, st_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          conv_q, conv_d, sck_q, sck_d;
  logic          req_nap, req_slp, go_run, seq_last;
  disc_load_e    ld;

  function automatic logic [SW-1:0] last_of(input seq_state_e s);
    case (s)
      ST_FRAME:  last_of = FR_LAST;
      ST_NAPSEQ: last_of = NAP_LAST;
      ST_SLPSEQ: last_of = SLP_LAST;
      default:   last_of = '0;
    endcase
  endfunction

  function automatic logic conv_lvl(input seq_state_e s, input logic [SW-1:0] k);
    case (s)
      ST_FRAME:             conv_lvl = (k == '0);
      ST_NAPSEQ, ST_SLPSEQ: conv_lvl = ~k[0];
      default:              conv_lvl = 1'b0;
    endcase
  endfunction

  always_comb begin
    req_slp  = mode_i[1];
    req_nap  = (mode_i == 2'b01);
    go_run   = (mode_i == 2'b00) && run_i;
    seq_last = (slot_q == last_of(st_q));
    st_d     = st_q;
    slot_d   = slot_q;
    ld       = LD_NONE;
    if (slot_end) begin
      if (!seq_last) begin
        slot_d = slot_q + 1'b1;
      end else begin
        slot_d = '0;
        case (st_q)
          ST_IDLE, ST_FRAME: begin
            if (req_slp) begin
              st_d = ST_SLPSEQ;
              ld   = LD_SLEEP;
            end else if (req_nap) begin
              st_d = ST_NAPSEQ;
              ld   = LD_NAP;
            end else if (go_run) begin
              st_d = ST_FRAME;
            end else begin
              st_d = ST_IDLE;
              if (st_q == ST_FRAME) ld = LD_STOP;
            end
          end
          ST_NAPSEQ: st_d = ST_NAPPED;
          ST_SLPSEQ: st_d = ST_SLEEPING;
          ST_NAPPED: begin
            if (req_slp) begin
              st_d = ST_SLPSEQ;
              ld   = LD_SLEEP;
            end else if (go_run) begin
              st_d = ST_WAKE;
            end
          end
          ST_SLEEPING: if (go_run) st_d = ST_WAKE;
          ST_WAKE:     st_d = ST_FRAME;
          default:     st_d = ST_IDLE;
        endcase
      end
    end
    conv_d = slot_end ? conv_lvl(st_d, slot_d) : conv_q;
    sck_d  = ((st_q == ST_FRAME) || (st_q == ST_WAKE)) && sck_hi_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      conv_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      if (slot_end) begin
        st_q   <= st_d;
        slot_q <= slot_d;
      end
      conv_q <= conv_d;
      sck_q  <= sck_d;
    end
  end

  assign conv_o     = conv_q;
  assign sclk_o     = sck_q;
  assign busy_o     = (st_q == ST_FRAME) || (st_q == ST_NAPSEQ) ||
                      (st_q == ST_SLPSEQ) || (st_q == ST_WAKE);
  assign in_frame_o = (st_q == ST_FRAME);
  assign slot_o     = slot_q;
  assign disc_ld_o  = ld;

endmodule

// File: rtl/adc_cap_shift.sv
module adc_cap_shift
  import adc_cap_pkg::*;
#(
  parameter int RES           = 14,
  parameter int MSB_POS       = 2,
  parameter int NAP_DISCARD   = 1,
  parameter int SLEEP_DISCARD = 2,
  parameter int SW            = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sdata_i,
  input  logic           sck_rise,
  input  logic           in_frame,
  input  logic [SW-1:0]  slot,
  input  disc_load_e     disc_ld,
  output logic [RES-1:0] data_o,
  output logic           valid_o
);

  localparam int DMAX0 = (NAP_DISCARD > SLEEP_DISCARD) ? NAP_DISCARD : SLEEP_DISCARD;
  localparam int DMAX  = (DMAX0 > 1) ? DMAX0 : 1;
  localparam int DCW   = $clog2(DMAX + 1);
  localparam logic [DCW-1:0] NAP_D = DCW'(NAP_DISCARD);
  localparam logic [DCW-1:0] SLP_D = DCW'(SLEEP_DISCARD);
  localparam logic [DCW-1:0] ONE_D = DCW'(1);
  localparam logic [SW-1:0]  FIRST_S = SW'(MSB_POS);
  localparam logic [SW-1:0]  LAST_S  = SW'(MSB_POS + RES - 1);

  logic [RES-2:0] sh_q, sh_d;
  logic [RES-1:0] data_q, data_d, word;
  logic           valid_q, valid_d, take, last;
  logic [DCW-1:0] disc_q, disc_d;

  always_comb begin
    take    = in_frame && sck_rise && (slot >= FIRST_S) && (slot <= LAST_S);
    last    = take && (slot == LAST_S);
    word    = {sh_q, sdata_i};
    sh_d    = take ? word[RES-2:0] : sh_q;
    valid_d = last && (disc_q == '0);
    data_d  = valid_d ? word : data_q;
    case (disc_ld)
      LD_SLEEP: disc_d = SLP_D;
      LD_NAP:   disc_d = NAP_D;
      LD_STOP:  disc_d = (disc_q == '0) ? ONE_D : disc_q;
      default:  disc_d = (last && (disc_q != '0)) ? disc_q - 1'b1 : disc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      disc_q  <= ONE_D;
    end else begin
      sh_q    <= sh_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      disc_q  <= disc_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DIV           = 4,
  parameter int RES           = 14,
  parameter int MSB_POS       = 2,
  parameter int SLEEP_PULSES  = 4,
  parameter int NAP_DISCARD   = 1,
  parameter int SLEEP_DISCARD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [1:0]     mode_i,
  input  logic           sdata_i,
  output logic           conv_o,
  output logic           sclk_o,
  output logic [RES-1:0] data_o,
  output logic           valid_o,
  output logic           busy_o
);

  localparam int MAX_SLOTS = (2 * SLEEP_PULSES > FRAME_SLOTS) ? 2 * SLEEP_PULSES : FRAME_SLOTS;
  localparam int SW        = $clog2(MAX_SLOTS);

  logic          rst_i_n;
  logic          slot_end, sck_hi_nxt, sck_rise_nxt, in_frame;
  logic [SW-1:0] slot;
  disc_load_e    disc_ld;

  adc_cap_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  adc_cap_clkgen #(.DIV(DIV)) u_clk (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .slot_end     (slot_end),
    .sck_hi_nxt   (sck_hi_nxt),
    .sck_rise_nxt (sck_rise_nxt)
  );

  adc_cap_seq #(.SLEEP_PULSES(SLEEP_PULSES), .SW(SW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .slot_end   (slot_end),
    .sck_hi_nxt (sck_hi_nxt),
    .run_i      (run_i),
    .mode_i     (mode_i),
    .conv_o     (conv_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .in_frame_o (in_frame),
    .slot_o     (slot),
    .disc_ld_o  (disc_ld)
  );

  adc_cap_shift #(
    .RES(RES), .MSB_POS(MSB_POS), .NAP_DISCARD(NAP_DISCARD),
    .SLEEP_DISCARD(SLEEP_DISCARD), .SW(SW)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sdata_i  (sdata_i),
    .sck_rise (sck_rise_nxt),
    .in_frame (in_frame),
    .slot     (slot),
    .disc_ld  (disc_ld),
    .data_o   (data_o),
    .valid_o  (valid_o)
  );

endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk #(
  parameter int DIV = 4,
  parameter int RES = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_o,
  input logic           sclk_o,
  input logic           valid_o,
  input logic           busy_o,
  input logic [RES-1:0] data_o
);

  localparam int CW = $clog2(DIV) + 2;

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (conv_o) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  // R2
  conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> (hi_cnt == CW'(DIV)));

  // R2
  conv_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> !sclk_o);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> valid_o);

  // R11
  quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!conv_o && !sclk_o));

endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(.DIV(DIV), .RES(RES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .conv_o  (conv_o),
  .sclk_o  (sclk_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .data_o  (data_o)
);

// File: tb/adc_capture_ctrl_tb.sv
module adc_cap_model #(
  parameter int RES     = 14,
  parameter int MSB_POS = 2
) (
  input  logic           clk,
  input  logic           conv,
  input  logic           sck,
  output logic           sdo,
  output logic [RES-1:0] exp_word,
  output int             idx,
  output int             conv_rises,
  output int             sck_rises,
  output int             width,
  output int             period
);
  logic pc, ps;
  logic [RES-1:0] cur;
  int n, cyc, last_rise, hcnt;

  function automatic logic [RES-1:0] pat(input int k);
    case (k % 4)
      0: pat = '1;
      1: pat = '0;
      2: pat = {(RES/2){2'b10}};
      default: pat = RES'(k * 911 + 77);
    endcase
  endfunction

  function automatic logic bitval(input int k, input logic [RES-1:0] w);
    if (k >= MSB_POS && k < MSB_POS + RES) bitval = w[RES-1-(k-MSB_POS)];
    else bitval = 1'b1;
  endfunction

  initial begin
    pc = 0; ps = 0; n = 0; cyc = 0; last_rise = 0; hcnt = 0;
    cur = pat(0); exp_word = '0; idx = 0; conv_rises = 0; sck_rises = 0;
    width = 0; period = 0; sdo = 1'b1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (conv && !pc) begin
      conv_rises = conv_rises + 1;
      period = cyc - last_rise;
      last_rise = cyc;
      idx = 0;
      exp_word = cur;
      n = n + 1;
      cur = pat(n);
      hcnt = 1;
    end else begin
      if (!sck && ps) idx = idx + 1;
      if (conv) hcnt = hcnt + 1;
    end
    if (!conv && pc) width = hcnt;
    if (sck && !ps) sck_rises = sck_rises + 1;
    sdo = bitval(idx, exp_word);
    pc = conv;
    ps = sck;
  end
endmodule

module adc_capture_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int MSB_POS = 2;

  logic clk, rst_n, run;
  logic [1:0] mode;
  logic sd14, sd12, conv14, conv12, sck14, sck12, v14, v12, busy14, busy12;
  logic [13:0] d14, ew14;
  logic [11:0] d12, ew12;
  int idx14, idx12, cr14, cr12, sr14, sr12, w14, w12, p14, p12;
  int checks, errors, nv14, nv12;

  adc_capture_ctrl #(.DIV(DIV), .RES(14), .MSB_POS(MSB_POS)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode), .sdata_i(sd14),
    .conv_o(conv14), .sclk_o(sck14), .data_o(d14), .valid_o(v14), .busy_o(busy14));

  adc_capture_ctrl #(.DIV(DIV), .RES(12), .MSB_POS(MSB_POS)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode), .sdata_i(sd12),
    .conv_o(conv12), .sclk_o(sck12), .data_o(d12), .valid_o(v12), .busy_o(busy12));

  adc_cap_model #(.RES(14), .MSB_POS(MSB_POS)) m14 (
    .clk(clk), .conv(conv14), .sck(sck14), .sdo(sd14), .exp_word(ew14), .idx(idx14),
    .conv_rises(cr14), .sck_rises(sr14), .width(w14), .period(p14));

  adc_cap_model #(.RES(12), .MSB_POS(MSB_POS)) m12 (
    .clk(clk), .conv(conv12), .sck(sck12), .sdo(sd12), .exp_word(ew12), .idx(idx12),
    .conv_rises(cr12), .sck_rises(sr12), .width(w12), .period(p12));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4 R5: every delivered word matches the model and arrives at the last data clock
  always @(negedge clk) begin
    if (rst_n && v14) begin
      nv14++;
      chk("R4 14-bit word", d14, ew14);
      chk("R5 valid at last data clock (14)", idx14, MSB_POS + 13);
    end
    if (rst_n && v12) begin
      nv12++;
      chk("R4 12-bit word", d12, ew12);
      chk("R5 valid at last data clock (12)", idx12, MSB_POS + 11);
    end
  end

  task automatic wait_rises(input int k);
    int base;
    base = cr14;
    wait (cr14 >= base + k);
    @(negedge clk);
  endtask

  task automatic wait_quiet();
    wait (busy14 == 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0; mode = 2'b00;
    repeat (4) @(negedge clk);
    chk("R1 conv low in reset", conv14, 0);
    chk("R1 sclk low in reset", sck14, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid low", v14, 0);
    chk("R1 busy low", busy14, 0);
    chk("R1 data zero", d14, 0);
    chk("R1 12-bit data zero", d12, 0);
  endtask

  task automatic t_run_start();
    int v0, v0b, s0;
    v0 = nv14; v0b = nv12;
    run = 1'b1;
    wait_rises(1);
    s0 = sr14;
    repeat (3) @(negedge clk);
    chk("R11 busy during frame", busy14, 1);
    wait_rises(3);
    chk("R2 convert width", w14, DIV);
    chk("R3 frame period", p14, 18 * DIV);
    chk("R3 serial clocks over three frames", sr14 - s0, 54);
    chk("R6 startup discard (14)", nv14 - v0, 2);
    chk("R6 startup discard (12)", nv12 - v0b, 2);
    v0 = nv14;
    wait_rises(4);
    chk("R4 words over pattern set", nv14 - v0, 4);
  endtask

  task automatic t_powerdown(input logic [1:0] m, input int pulses, input string tag);
    int c0, s0, v0;
    wait_rises(1);
    mode = m;
    c0 = cr14; s0 = sr14; v0 = nv14;
    wait_quiet();
    chk({tag, " convert pulses"}, cr14 - c0, pulses);
    chk({"R7 frame completes before ", tag}, sr14 - s0, 18);
    chk({"R7 word delivered before ", tag}, nv14 - v0, 1);
    c0 = cr14; s0 = sr14;
    repeat (200) @(negedge clk);
    chk("R11 no convert while powered down", cr14 - c0, 0);
    chk("R11 no clock while powered down", sr14 - s0, 0);
    chk("R11 busy low while powered down", busy14, 0);
  endtask

  task automatic t_wake(input int discard, input string tag);
    int s0, v0;
    s0 = sr14; v0 = nv14;
    mode = 2'b00;
    wait_rises(1);
    chk("R10 one clock before first frame", sr14 - s0, 1);
    wait_rises(3);
    chk(tag, nv14 - v0, 3 - discard);
  endtask

  task automatic t_stop();
    int c0, s0, v0;
    wait_rises(1);
    run = 1'b0;
    c0 = cr14; s0 = sr14; v0 = nv14;
    wait_quiet();
    chk("R12 frame completes on stop", sr14 - s0, 18);
    chk("R12 word delivered on stop", nv14 - v0, 1);
    repeat (150) @(negedge clk);
    chk("R12 no convert after stop", cr14 - c0, 0);
    chk("R11 busy low when idle", busy14, 0);
    v0 = nv14;
    run = 1'b1;
    wait_rises(4);
    chk("R6 restart discard", nv14 - v0, 2);
  endtask

  initial begin
    checks = 0; errors = 0; nv14 = 0; nv12 = 0;
    rst_n = 1'b0; run = 1'b0; mode = 2'b00;
    fork
      begin
        t_reset();
        t_run_start();
        t_powerdown(2'b01, 2, "R8 nap");
        t_wake(1, "R6 nap wake discard");
        t_powerdown(2'b10, 4, "R9 sleep");
        t_wake(2, "R6 sleep wake discard");
        t_stop();
      end
      begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog R1-all: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule